// File: doc/BRIEF.md
# Address Translation Unit with Two-Level Table Walk

The block turns a 32-bit virtual address into a physical address. A fully associative buffer of recent translations is searched first; when it holds the page, the answer appears one cycle after the request is accepted and memory is not touched. On a miss, a walker reads a directory entry, then a page-table entry, through a request/acknowledge memory port. It writes the table entry back with its referenced flag set, installs the translation in the buffer and reports the physical address.

The virtual address splits into a 10-bit directory index (bits 31:22), a 10-bit table index (bits 21:12) and a 12-bit page offset (bits 11:0). Every table entry is 32 bits: bit 0 marks the entry present, bit 1 marks it referenced, and bits 31:12 carry either the base of the next-level table or the page frame. When either level lacks the present flag, the walk stops and a one-cycle fault strobe is raised instead of a completion. An invalidate-all input empties the buffer.

Top module: `xlat_unit`

## Requirements
- R1: On a miss, the first memory access is a read at address `dir_base + 4 * vaddr[31:22]`.
- R2: The second access is a read at `{dir_entry[31:12], 12'h000} + 4 * vaddr[21:12]`, where `dir_entry` is the word returned by the first read.
- R3: The reported physical address is the frame field `pte[31:12]` of the page-table entry joined with the unchanged `vaddr[11:0]`.
- R4: A request whose page is held in the buffer raises `done` in the cycle right after acceptance, with no memory access.
- R5: A successful walk makes exactly three accesses: directory read, table read, then a write to the table-entry address of the read word with bit 1 set; `done` rises in the cycle after the write is acknowledged.
- R6: A directory entry with bit 0 clear ends the walk after that single read and raises `fault` for exactly one cycle; nothing is installed, so the same page walks again.
- R7: A table entry with bit 0 clear ends the walk after two reads, with no write, raises `fault` for one cycle and installs nothing.
- R8: The buffer holds 32 translations; once 32 distinct pages have been walked, all 32 hit.
- R9: A fill into a full buffer replaces entries in round-robin order starting at the slot filled first; free slots are always used before any entry is replaced.
- R10: A one-cycle `flush_all` pulse invalidates every entry, so each later request walks.
- R11: A memory request holds its address, direction and data until acknowledged; `ready` is low during a walk, and `req_valid` while `ready` is low is ignored.
- R12: After reset `ready` is high, `done`, `fault` and `mem_req` are low and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request, taken when `ready` is high |
| req_vaddr | input | 32 | Virtual address to translate |
| dir_base | input | 32 | Byte address of the directory table |
| flush_all | input | 1 | Invalidate every buffered translation |
| ready | output | 1 | Block idle and able to take a request |
| done | output | 1 | One-cycle strobe: `paddr` is valid |
| fault | output | 1 | One-cycle strobe: an entry lacked its present flag |
| paddr | output | 32 | Physical address of the last completed request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench counts memory accesses per request, so a design that walked on a hit, skipped the write-back or kept going after a missing present flag shows the wrong access count, and one that installed a faulting page would answer the retry without touching memory. Replacement is probed by filling all 32 slots, adding one more page, and checking that the second-filled page still hits while the first-filled one walks; a fixed-slot or last-slot victim choice fails that pattern. Translations through two different directory entries catch index slicing or shift errors in both entry addresses, and a request held high during a walk must not disturb the result or be taken on its own.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int PTE_PRESENT = 0;
  localparam int PTE_REFD    = 1;

  typedef enum logic [1:0] {
    WK_IDLE,
    WK_DIR,
    WK_PTE,
    WK_WB
  } walk_st_t;
endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 20,
  parameter int DATA_W  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic              flush,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int SEL_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [DATA_W-1:0]  dat_q [ENTRIES];
  logic [SEL_W-1:0]   rr_q, rr_d, free_sel, slot;
  logic               any_free, wr_en;

  assign wr_en = fill_en && !flush;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign match[g] = vld_q[g] && (tag_q[g] == lk_tag);

    always_ff @(posedge clk) begin
      if (wr_en && (slot == SEL_W'(g))) begin
        tag_q[g] <= fill_tag;
        dat_q[g] <= fill_data;
      end
    end
  end

  always_comb begin
    lk_hit  = |match;
    lk_data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) lk_data = lk_data | dat_q[i];
    end
  end

  // lowest free slot wins; the round-robin pointer only moves on replacement
  always_comb begin
    any_free = 1'b0;
    free_sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        any_free = 1'b1;
        free_sel = SEL_W'(i);
      end
    end
    slot = any_free ? free_sel : rr_q;
  end

  always_comb begin
    vld_d = vld_q;
    rr_d  = rr_q;
    if (flush) begin
      vld_d = '0;
    end else if (fill_en) begin
      vld_d[slot] = 1'b1;
      if (!any_free) begin
        rr_d = (rr_q == SEL_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
    end else begin
      vld_q <= vld_d;
      rr_q  <= rr_d;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int IDX_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [VA_W-1:0]       start_va,
  input  logic [VA_W-1:0]       start_base,
  output logic                  idle,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [VA_W-1:0]       mem_addr,
  output logic [VA_W-1:0]       mem_wdata,
  input  logic                  mem_ack,
  input  logic [VA_W-1:0]       mem_rdata,
  output logic                  fill_en,
  output logic [VA_W-OFF_W-1:0] fill_vpn,
  output logic [VA_W-OFF_W-1:0] fill_pfn,
  output logic [OFF_W-1:0]      fill_off,
  output logic                  walk_fault
);
  localparam int PN_W = VA_W - OFF_W;

  walk_st_t          st_q, st_d;
  logic [VA_W-1:0]   va_q, base_q, pte_q;
  logic [PN_W-1:0]   tbl_q;
  logic              ld_req, ld_tbl, ld_pte, present;
  logic [IDX_W-1:0]  dir_idx, tbl_idx;
  logic [VA_W-1:0]   dir_addr, pte_addr;

  assign dir_idx  = va_q[OFF_W+2*IDX_W-1 -: IDX_W];
  assign tbl_idx  = va_q[OFF_W+IDX_W-1 -: IDX_W];
  assign dir_addr = base_q + VA_W'({dir_idx, 2'b00});
  assign pte_addr = {tbl_q, {OFF_W{1'b0}}} + VA_W'({tbl_idx, 2'b00});
  assign present  = mem_rdata[PTE_PRESENT];

  always_comb begin
    st_d       = st_q;
    ld_req     = 1'b0;
    ld_tbl     = 1'b0;
    ld_pte     = 1'b0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_addr   = pte_addr;
    mem_wdata  = pte_q | (VA_W'(1) << PTE_REFD);
    fill_en    = 1'b0;
    walk_fault = 1'b0;
    case (st_q)
      WK_IDLE: begin
        if (start) begin
          ld_req = 1'b1;
          st_d   = WK_DIR;
        end
      end
      WK_DIR: begin
        mem_req  = 1'b1;
        mem_addr = dir_addr;
        if (mem_ack) begin
          if (present) begin
            ld_tbl = 1'b1;
            st_d   = WK_PTE;
          end else begin
            walk_fault = 1'b1;
            st_d       = WK_IDLE;
          end
        end
      end
      WK_PTE: begin
        mem_req = 1'b1;
        if (mem_ack) begin
          if (present) begin
            ld_pte = 1'b1;
            st_d   = WK_WB;
          end else begin
            walk_fault = 1'b1;
            st_d       = WK_IDLE;
          end
        end
      end
      WK_WB: begin
        mem_req = 1'b1;
        mem_we  = 1'b1;
        if (mem_ack) begin
          fill_en = 1'b1;
          st_d    = WK_IDLE;
        end
      end
      default: st_d = WK_IDLE;
    endcase
  end

  assign idle     = (st_q == WK_IDLE);
  assign fill_vpn = va_q[VA_W-1:OFF_W];
  assign fill_pfn = pte_q[VA_W-1:OFF_W];
  assign fill_off = va_q[OFF_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= WK_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk) begin
    if (ld_req) begin
      va_q   <= start_va;
      base_q <= start_base;
    end
    if (ld_tbl) tbl_q <= mem_rdata[VA_W-1:OFF_W];
    if (ld_pte) pte_q <= mem_rdata;
  end
endmodule

// File: rtl/xlat_unit.sv
module xlat_unit #(
  parameter int VA_W        = 32,
  parameter int OFF_W       = 12,
  parameter int IDX_W       = 10,
  parameter int TLB_ENTRIES = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [VA_W-1:0] dir_base,
  input  logic            flush_all,
  output logic            ready,
  output logic            done,
  output logic            fault,
  output logic [VA_W-1:0] paddr,
  output logic            mem_req,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata
);
  localparam int PN_W = VA_W - OFF_W;

  logic            accept, hit_go, walk_go, lk_hit;
  logic [PN_W-1:0] lk_pfn, fill_vpn, fill_pfn;
  logic [OFF_W-1:0] fill_off;
  logic            fill_en, walk_fault, walk_idle;
  logic            done_q, fault_q, pa_en;
  logic [VA_W-1:0] paddr_q, paddr_d;

  assign ready   = walk_idle;
  assign accept  = req_valid && walk_idle;
  assign hit_go  = accept && lk_hit;
  assign walk_go = accept && !lk_hit;

  xlat_cam #(
    .ENTRIES (TLB_ENTRIES),
    .TAG_W   (PN_W),
    .DATA_W  (PN_W)
  ) u_cam (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_tag    (req_vaddr[VA_W-1:OFF_W]),
    .lk_hit    (lk_hit),
    .lk_data   (lk_pfn),
    .flush     (flush_all),
    .fill_en   (fill_en),
    .fill_tag  (fill_vpn),
    .fill_data (fill_pfn)
  );

  xlat_walker #(
    .VA_W  (VA_W),
    .OFF_W (OFF_W),
    .IDX_W (IDX_W)
  ) u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (walk_go),
    .start_va   (req_vaddr),
    .start_base (dir_base),
    .idle       (walk_idle),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .fill_off   (fill_off),
    .walk_fault (walk_fault)
  );

  always_comb begin
    pa_en   = hit_go || fill_en;
    paddr_d = hit_go ? {lk_pfn, req_vaddr[OFF_W-1:0]} : {fill_pfn, fill_off};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      done_q  <= pa_en;
      fault_q <= walk_fault;
    end
  end

  always_ff @(posedge clk) begin
    if (pa_en) paddr_q <= paddr_d;
  end

  assign done  = done_q;
  assign fault = fault_q;
  assign paddr = paddr_q;
endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        ready,
  input logic        done,
  input logic        fault,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata
);
  p_fault_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(mem_req && mem_ack && !mem_we && !mem_rdata[0]));

  p_done_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(req_valid && ready) || $past(mem_req && mem_ack && mem_we)));

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !ready);

  p_wb_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata[1:0] == 2'b11));
endmodule

bind xlat_unit xlat_unit_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .ready     (ready),
  .done      (done),
  .fault     (fault),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdata (mem_rdata)
);

// File: tb/xlat_unit_bench.sv
module xlat_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] DIRB  = 32'h0010_0000;
  localparam logic [31:0] TBL1  = 32'h0020_0000;
  localparam logic [31:0] TBL3  = 32'h0025_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [31:0] dir_base = DIRB;
  logic        flush_all = 1'b0;
  logic        ready, done, fault, mem_req, mem_we;
  logic [31:0] paddr, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [int unsigned];
  int          n_chk = 0, n_bad = 0, cyc_total = 0, acc_cnt = 0;
  logic [31:0] acc_addr [8];
  logic        acc_we [8];
  bit          finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_unit u_xlat_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .dir_base(dir_base), .flush_all(flush_all), .ready(ready), .done(done),
    .fault(fault), .paddr(paddr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
    end
    mem_ack <= mem_req && !mem_ack;
    if (mem_req && mem_ack) begin
      acc_addr[acc_cnt % 8] <= mem_addr;
      acc_we[acc_cnt % 8]   <= mem_we;
      acc_cnt <= acc_cnt + 1;
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000 && !finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc_total);
      summary();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] va(input int d, input int t, input int off);
    return {d[9:0], t[9:0], off[11:0]};
  endfunction

  function automatic logic [19:0] frm1(input int t);
    return 20'h40000 + 20'(t * 3);
  endfunction

  task automatic translate(input logic [31:0] v, output logic [31:0] pa,
                           output logic flt, output int cyc, output int nacc);
    int a0;
    a0 = acc_cnt;
    cyc = 0; flt = 1'b0; pa = '0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    a0 = acc_cnt;
    req_vaddr = v; req_valid = 1'b1;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      cyc++;
      if (done || fault) break;
    end
    pa = paddr; flt = fault;
    if (!(done || fault)) begin
      n_chk++; n_bad++;
      $display("FAIL timeout: act=no completion exp=done or fault");
    end
    nacc = acc_cnt - a0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_all = 1'b1;
    @(negedge clk);
    flush_all = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 ready", 32'(ready), 32'd1);
    chk("R12 done", 32'(done), 32'd0);
    chk("R12 fault", 32'(fault), 32'd0);
    chk("R12 mem_req", 32'(mem_req), 32'd0);
  endtask

  task automatic t_walk_then_hit();
    logic [31:0] pa; logic f; int c, n;
    translate(va(1, 5, 'habc), pa, f, c, n);
    chk("R5 access count", 32'(n), 32'd3);
    chk("R1 dir addr", acc_addr[(acc_cnt-3) % 8], DIRB + 32'd4);
    chk("R2 pte addr", acc_addr[(acc_cnt-2) % 8], TBL1 + 32'd20);
    chk("R5 wb addr", acc_addr[(acc_cnt-1) % 8], TBL1 + 32'd20);
    chk("R5 wb is write", 32'(acc_we[(acc_cnt-1) % 8]), 32'd1);
    chk("R5 referenced set", mem[TBL1 + 32'd20], {frm1(5), 12'h003});
    chk("R3 paddr walk", pa, {frm1(5), 12'habc});
    chk("R5 no fault", 32'(f), 32'd0);
    translate(va(1, 5, 'h123), pa, f, c, n);
    chk("R4 hit cycles", 32'(c), 32'd1);
    chk("R4 hit accesses", 32'(n), 32'd0);
    chk("R3 paddr hit", pa, {frm1(5), 12'h123});
    translate(va(3, 7, 'h7fe), pa, f, c, n);
    chk("R1 dir addr d3", acc_addr[(acc_cnt-3) % 8], DIRB + 32'd12);
    chk("R2 pte addr d3", acc_addr[(acc_cnt-2) % 8], TBL3 + 32'd28);
    chk("R3 paddr d3", pa, {20'h50007, 12'h7fe});
  endtask

  task automatic t_dir_fault();
    logic [31:0] pa; logic f; int c, n;
    for (int r = 0; r < 2; r++) begin
      translate(va(2, 4, 0), pa, f, c, n);
      chk("R6 fault", 32'(f), 32'd1);
      chk("R6 one read only", 32'(n), 32'd1);
      @(negedge clk);
      chk("R6 fault one cycle", 32'(fault), 32'd0);
    end
  endtask

  task automatic t_pte_fault();
    logic [31:0] pa; logic f; int c, n;
    for (int r = 0; r < 2; r++) begin
      translate(va(1, 100, 0), pa, f, c, n);
      chk("R7 fault", 32'(f), 32'd1);
      chk("R7 two reads", 32'(n), 32'd2);
      chk("R7 no write", 32'(acc_we[(acc_cnt-1) % 8]), 32'd0);
    end
  endtask

  task automatic t_capacity_rr();
    logic [31:0] pa; logic f; int c, n, hits;
    do_flush();
    for (int t = 0; t < 32; t++) translate(va(1, t, 0), pa, f, c, n);
    hits = 0;
    for (int t = 0; t < 32; t++) begin
      translate(va(1, t, 'h10), pa, f, c, n);
      if (n == 0 && pa == {frm1(t), 12'h010}) hits++;
    end
    chk("R8 all 32 hit", 32'(hits), 32'd32);
    translate(va(1, 32, 0), pa, f, c, n);
    chk("R9 33rd page walks", 32'(n), 32'd3);
    translate(va(1, 1, 0), pa, f, c, n);
    chk("R9 second slot kept", 32'(n), 32'd0);
    translate(va(1, 0, 0), pa, f, c, n);
    chk("R9 first slot evicted", 32'(n), 32'd3);
    translate(va(1, 1, 0), pa, f, c, n);
    chk("R9 next victim is slot 1", 32'(n), 32'd3);
    translate(va(1, 32, 0), pa, f, c, n);
    chk("R9 newest kept", 32'(n), 32'd0);
  endtask

  task automatic t_flush();
    logic [31:0] pa; logic f; int c, n;
    translate(va(1, 5, 0), pa, f, c, n);
    translate(va(1, 5, 0), pa, f, c, n);
    chk("R10 hit before flush", 32'(n), 32'd0);
    do_flush();
    translate(va(1, 5, 0), pa, f, c, n);
    chk("R10 walk after flush", 32'(n), 32'd3);
    chk("R10 paddr after flush", pa, {frm1(5), 12'h000});
  endtask

  task automatic t_busy();
    logic [31:0] pa; logic f; int c, n, a0;
    do_flush();
    @(negedge clk);
    a0 = acc_cnt;
    req_vaddr = va(1, 9, 'h055); req_valid = 1'b1;
    @(negedge clk);
    chk("R11 ready low in walk", 32'(ready), 32'd0);
    req_vaddr = va(1, 10, 'h0aa);
    @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done) break;
      @(negedge clk);
    end
    chk("R11 result of first request", paddr, {frm1(9), 12'h055});
    chk("R11 three accesses", 32'(acc_cnt - a0), 32'd3);
    translate(va(1, 10, 0), pa, f, c, n);
    chk("R11 ignored request walks later", 32'(n), 32'd3);
  endtask

  initial begin
    mem[DIRB + 32'd4]  = TBL1 | 32'h1;
    mem[DIRB + 32'd12] = TBL3 | 32'h1;
    for (int t = 0; t < 41; t++) mem[TBL1 + 32'(t * 4)] = {frm1(t), 12'h001};
    mem[TBL3 + 32'd28] = {20'h50007, 12'h001};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk_then_hit();
    t_dir_fault();
    t_pte_fault();
    t_capacity_rr();
    t_flush();
    t_busy();
    finished = 1'b1;
    summary();
  end
endmodule